// File: doc/BRIEF.md
# Serial ADC Result Readout Master

This block is the controlling end of a three-wire link to a serial analog-to-digital converter. A one-cycle pulse on `start` opens a transaction. The block drives the active-low select line low and generates a serial clock from the system clock. It then samples the converter's data line and assembles a 12-bit result. The result is presented on `result` together with a single-cycle `result_valid` strobe. The serial clock idles low. Data is taken only when the serial clock goes high, because the converter changes its output after each falling clock edge. Bits arrive most-significant first.

Two framings are supported, chosen per transaction by `mode_single`. In byte mode the block runs two groups of eight clocks, separated by a short pause with the select line held low. Result bits 11..4 arrive in the first group and bits 3..0 open the second group. In single mode one burst of 12 to 16 clocks is issued. In both modes only the first twelve received bits form the result, and anything after them is dropped. The clock period is `DIV_RATIO` system cycles. A ratio of 16 at a 128 MHz system clock gives an 8 MHz serial clock, which is the highest rate the converter accepts.

Top module: `adc_readout_master`

## Requirements
- R1: After synchronous reset `cs_n` is 1, `sclk` is 0, `busy` is 0, `result_valid` is 0 and `result` is 0.
- R2: `sclk` is 0 whenever no transaction is running. Each high phase of `sclk` lasts DIV_RATIO/2 system cycles. DIV_RATIO is even and at least 2.
- R3: With `mode_single`=0 (byte mode) the block issues 16 rising edges of `sclk` in two groups of 8. After the 8th falling edge, `sclk` stays low for GAP_CYC extra cycles while `cs_n` stays low. `result` equals the first 12 bits received, with the first bit at bit 11.
- R4: With `mode_single`=1 the block issues SGL_CLKS rising edges (12 to 16) in one unbroken burst. `result` equals the first 12 bits received, with the first bit at bit 11.
- R5: Bits received after the 12th have no effect on `result`.
- R6: The data line is sampled in the system cycle in which `sclk` goes from 0 to 1. `sclk` never rises while `cs_n` is high.
- R7: `result_valid` is high for exactly one cycle per transaction. It rises in the same cycle that `cs_n` returns high, and `result` holds its value until the next transaction completes.
- R8: A `start` pulse while `busy` is 1 is ignored. The running frame keeps its length and result, and no further frame follows it.
- R9: `busy` is 1 from the cycle after an accepted `start` until `result_valid` rises. `busy` falls in the cycle `result_valid` rises.
- R10: `cs_n` stays low for DIV_RATIO/2 + N*DIV_RATIO cycles per frame, where N is the number of clocks in the frame. In byte mode GAP_CYC more cycles are added.
- R11: `mode_single` is taken when `start` is accepted. Changing it during a transaction has no effect on that transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | One-cycle request to read a result |
| mode_single | input | 1 | 1: single burst of SGL_CLKS clocks; 0: two 8-clock groups |
| sdata_in | input | 1 | Serial data from the converter |
| cs_n | output | 1 | Select / convert-start, active low |
| sclk | output | 1 | Serial clock, idles low |
| busy | output | 1 | Transaction in progress |
| result | output | 12 | Last assembled result |
| result_valid | output | 1 | One-cycle strobe when `result` is updated |

## Verification
The bench uses a small setting: a divider of 4, a byte-mode pause of 3 cycles and a 14-clock single burst. A converter model in the bench shifts a chosen word out after each falling clock edge and drives alternating filler after the twelfth bit.

Words are swept in both framings: all zeros, all ones, walking ones and a strided sweep. Together these show whether bit order, the merge across the byte pause and the dropping of trailing filler are correct. For every frame the bench also counts clock edges, high-phase width and select-low cycles, which tells the byte framing apart from the single framing.

Further frames inject a `start` pulse or flip `mode_single` partway through. These show whether either disturbance leaks into the frame that is running.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_LEAD = 3'd1,
    ST_HI   = 3'd2,
    ST_LO   = 3'd3,
    ST_GAP  = 3'd4
  } rd_state_t;
endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] load_len,
  output logic          expire
);
  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= '0;
    else if (load)
      cnt <= load_len - TW'(1);
    else if (cnt != '0)
      cnt <= cnt - TW'(1);
  end

  assign expire = (cnt == '0);
endmodule

// File: rtl/adc_rd_shift.sv
module adc_rd_shift #(
  parameter int RES_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             take,
  input  logic             din,
  input  logic             load_out,
  output logic [RES_W-1:0] result
);
  localparam int NW = $clog2(RES_W + 1);

  logic [RES_W-1:0] sh;
  logic [NW-1:0]    cap_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh     <= '0;
      cap_n  <= '0;
      result <= '0;
    end else begin
      if (clr)
        cap_n <= '0;
      else if (take && (cap_n < NW'(RES_W))) begin
        sh    <= {sh[RES_W-2:0], din};
        cap_n <= cap_n + NW'(1);
      end
      if (load_out)
        result <= sh;
    end
  end

  // capture count never passes the word width
  assert_no_extra_bits_R5: assert property (@(posedge clk) disable iff (rst)
    cap_n <= NW'(RES_W));
  // a frame only completes once the whole word is in
  assert_full_word_R3: assert property (@(posedge clk) disable iff (rst)
    load_out |-> (cap_n == NW'(RES_W)));
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int HALF     = 8,
  parameter int GAP_CYC  = 2,
  parameter int SGL_CLKS = 16,
  parameter int BYTE_W   = 8,
  parameter int TW       = 4,
  parameter int CW       = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          mode_single,
  input  logic          expire,
  output logic          load,
  output logic [TW-1:0] load_len,
  output logic          take,
  output logic          accept,
  output logic          finish,
  output logic          cs_n,
  output logic          sclk,
  output logic          busy,
  output logic          valid
);
  rd_state_t     st;
  logic          mode_q;
  logic [CW-1:0] bit_cnt;
  logic [CW-1:0] total;
  logic          to_gap;

  assign total = mode_q ? CW'(SGL_CLKS) : CW'(2 * BYTE_W);

  always_comb begin
    load     = 1'b0;
    load_len = TW'(HALF);
    take     = 1'b0;
    accept   = 1'b0;
    finish   = 1'b0;
    to_gap   = 1'b0;
    unique case (st)
      ST_IDLE: if (start) begin accept = 1'b1; load = 1'b1; end
      ST_LEAD: if (expire) begin take = 1'b1; load = 1'b1; end
      ST_HI:   if (expire) load = 1'b1;
      ST_LO: if (expire) begin
        if (bit_cnt == total)
          finish = 1'b1;
        else if (!mode_q && (bit_cnt == CW'(BYTE_W))) begin
          to_gap   = 1'b1;
          load     = 1'b1;
          load_len = TW'(GAP_CYC);
        end else begin
          take = 1'b1;
          load = 1'b1;
        end
      end
      ST_GAP:  if (expire) begin take = 1'b1; load = 1'b1; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      mode_q  <= 1'b0;
      bit_cnt <= '0;
      cs_n    <= 1'b1;
      sclk    <= 1'b0;
      busy    <= 1'b0;
      valid   <= 1'b0;
    end else begin
      valid <= 1'b0;
      if (accept) begin
        st      <= ST_LEAD;
        mode_q  <= mode_single;
        bit_cnt <= '0;
        cs_n    <= 1'b0;
        busy    <= 1'b1;
      end else if (take) begin
        st      <= ST_HI;
        sclk    <= 1'b1;
        bit_cnt <= bit_cnt + CW'(1);
      end else if (finish) begin
        st    <= ST_IDLE;
        cs_n  <= 1'b1;
        busy  <= 1'b0;
        valid <= 1'b1;
      end else if (to_gap) begin
        st <= ST_GAP;
      end else if (load && (st == ST_HI)) begin
        st   <= ST_LO;
        sclk <= 1'b0;
      end
    end
  end

  // framing choice is frozen while a frame runs
  assert_mode_frozen_R11: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy) |-> $stable(mode_q));
  // clock edges only inside a selected frame
  assert_rise_in_frame_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(sclk) |-> !cs_n);
  // a start while busy does not restart the frame
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (bit_cnt >= $past(bit_cnt)) || valid);
endmodule

// File: rtl/adc_readout_master.sv
module adc_readout_master #(
  parameter int DIV_RATIO = 16,
  parameter int GAP_CYC   = 2,
  parameter int SGL_CLKS  = 16,
  parameter int RES_W     = 12,
  parameter int BYTE_W    = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             mode_single,
  input  logic             sdata_in,
  output logic             cs_n,
  output logic             sclk,
  output logic             busy,
  output logic [RES_W-1:0] result,
  output logic             result_valid
);
  localparam int HALF  = DIV_RATIO / 2;
  localparam int TMAX  = (HALF > GAP_CYC) ? HALF : GAP_CYC;
  localparam int TW    = $clog2(TMAX + 1);
  localparam int NMAX  = (SGL_CLKS > 2 * BYTE_W) ? SGL_CLKS : 2 * BYTE_W;
  localparam int CW    = $clog2(NMAX + 1);

  logic          load;
  logic [TW-1:0] load_len;
  logic          expire;
  logic          take;
  logic          accept;
  logic          finish;

  adc_rd_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst(rst), .load(load), .load_len(load_len), .expire(expire)
  );

  adc_rd_ctrl #(
    .HALF(HALF), .GAP_CYC(GAP_CYC), .SGL_CLKS(SGL_CLKS),
    .BYTE_W(BYTE_W), .TW(TW), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .mode_single(mode_single),
    .expire(expire), .load(load), .load_len(load_len), .take(take),
    .accept(accept), .finish(finish), .cs_n(cs_n), .sclk(sclk),
    .busy(busy), .valid(result_valid)
  );

  adc_rd_shift #(.RES_W(RES_W)) u_shift (
    .clk(clk), .rst(rst), .clr(accept), .take(take), .din(sdata_in),
    .load_out(finish), .result(result)
  );

  // clock rests low outside frames
  assert_sclk_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !sclk);
  // strobe lasts one cycle
  assert_valid_pulse_R7: assert property (@(posedge clk) disable iff (rst)
    result_valid |=> !result_valid);
  // strobe coincides with deselect and end of busy
  assert_valid_end_R9: assert property (@(posedge clk) disable iff (rst)
    result_valid |-> (cs_n && !busy));
  // result only moves with the strobe
  assert_result_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !result_valid |-> $stable(result));
endmodule

// File: tb/tb_adc_readout_master.sv
module tb_adc_readout_master;
  localparam int DIV  = 4;
  localparam int HALF = DIV / 2;
  localparam int GAP  = 3;
  localparam int SGL  = 14;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic mode_single = 1'b0;
  logic sdata_in = 1'b0;
  logic cs_n, sclk, busy, result_valid;
  logic [11:0] result;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  logic [11:0] w = '0;

  always #2.5 clk = ~clk;

  adc_readout_master #(
    .DIV_RATIO(DIV), .GAP_CYC(GAP), .SGL_CLKS(SGL), .RES_W(12), .BYTE_W(8)
  ) dut (
    .clk(clk), .rst(rst), .start(start), .mode_single(mode_single),
    .sdata_in(sdata_in), .cs_n(cs_n), .sclk(sclk), .busy(busy),
    .result(result), .result_valid(result_valid)
  );

  // converter model: next bit after each falling sclk, filler past bit 12
  int idx = 0;
  logic sclk_p = 1'b0;
  logic cs_p = 1'b1;
  always @(posedge clk) begin
    #1;
    if (cs_p && !cs_n) idx = 0;
    else if (sclk_p && !sclk) idx = idx + 1;
    sdata_in = (idx < 12) ? w[11 - idx] : idx[0];
    sclk_p = sclk;
    cs_p = cs_n;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // disturb: 0 none, 1 start pulse mid-frame, 2 mode flip mid-frame
  task automatic frame(input logic [11:0] wv, input logic msel, input int disturb);
    int lowc = 0;
    int rises = 0;
    int hlen = 0;
    int hbad = 0;
    int busybad = 0;
    int n = 0;
    logic sp = 1'b0;
    int expn = msel ? SGL : 16;
    int explow = HALF + expn * DIV + (msel ? 0 : GAP);
    w = wv;
    mode_single = msel;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    while (!result_valid && n < 1000) begin
      if (!cs_n) lowc++;
      if (!cs_n && !busy) busybad++;
      if (sclk && !sp) rises++;
      if (sclk) hlen++;
      if (!sclk && sp) begin
        if (hlen != HALF) hbad++;
        hlen = 0;
      end
      sp = sclk;
      start = (disturb == 1 && (n == 9 || n == 30));
      if (disturb == 2 && n == 5) mode_single = ~msel;
      n++;
      @(negedge clk);
    end
    start = 1'b0;
    chk(result_valid === 1'b1, "R7 valid seen", int'(result_valid), 1);
    chk(cs_n === 1'b1 && busy === 1'b0, "R9 end of busy", int'(busy), 0);
    chk(result === wv, msel ? "R4/R5 result" : "R3/R5 result", int'(result), int'(wv));
    chk(rises == expn, msel ? "R4 clock count" : "R3 clock count", rises, expn);
    chk(lowc == explow, "R10 select-low cycles", lowc, explow);
    chk(hbad == 0, "R2 high phase width", hbad, 0);
    chk(busybad == 0, "R9 busy while selected", busybad, 0);
    if (disturb != 0) chk(1'b1, disturb == 1 ? "R8" : "R11", 0, 0);
    @(negedge clk);
    chk(result_valid === 1'b0, "R7 single pulse", int'(result_valid), 0);
    mode_single = msel;
    for (int k = 0; k < 6; k++) begin
      if (!cs_n || sclk) begin
        chk(1'b0, "R8/R2 no extra frame", int'(cs_n), 1);
        break;
      end
      @(negedge clk);
    end
    chk(result === wv, "R7 result holds", int'(result), int'(wv));
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(cs_n === 1'b1 && sclk === 1'b0 && busy === 1'b0, "R1 reset lines", int'(sclk), 0);
    chk(result_valid === 1'b0 && result === 12'd0, "R1 reset result", int'(result), 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    chk(sclk === 1'b0 && cs_n === 1'b1, "R2 idle clock low", int'(sclk), 0);
    for (int m = 0; m < 2; m++) begin
      frame(12'h000, m[0], 0);
      frame(12'hFFF, m[0], 0);
      for (int b = 0; b < 12; b++) frame(12'(1 << b), m[0], 0);
      for (int b = 0; b < 12; b++) frame(~12'(1 << b), m[0], 0);
      for (int v = 5; v < 4096; v += 37) frame(12'(v), m[0], 0);
    end
    frame(12'hA5C, 1'b0, 1);
    frame(12'h3C9, 1'b1, 1);
    frame(12'h6B1, 1'b0, 2);
    frame(12'h94E, 1'b1, 2);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule